// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the per-pin routing table of an interrupt controller and lets a bus master reach it through two memory-mapped locations: a 32-bit select register and a 32-bit data window. The value in the select register chooses what the window exposes. It can be a read-only version word, a 4-bit identification field, an arbitration word that mirrors the identification field, or one 32-bit half of a 64-bit routing entry. Each routing entry carries a vector, a delivery mode, a destination mode, a polarity, a trigger mode, a mask and a destination.

The whole table is exported flat to the interrupt servicing logic. That logic drives the per-pin pending-request vector through set and clear inputs, and it can set an entry's remote-IRR flag. A write to an entry produces two outputs. If the write flips the entry's mask bit, the block pulses a mask-change output. If the written pin has a request pending, the block strobes a service request so that the servicing logic evaluates the pin again. Delivery and end-of-interrupt handling are left to the servicing logic.

Top module: `irq_route_regfile`

## Requirements
- R1: Only the low 8 address bits are decoded. Offset 0x00 is the select register, which reads back all 32 bits. Offset 0x10 is the data window. A read of any other offset returns zero, and `bus_rdata` is zero when `bus_rd` is low.
- R2: Select value 0 reads the version word. It has bits 23:16 = NPINS-1, bits 7:0 = VERSION and all other bits zero (0x00170011 with the defaults). A window write at select 0 changes nothing.
- R3: Select value 1 is the identification register, which writes and reads a 4-bit ID in bits 27:24 with all other bits read as zero. Select value 2 reads the same ID in the same bits, and a write to it changes nothing.
- R4: Any other select value S addresses routing entry (S-0x10)>>1, computed in 32-bit unsigned arithmetic. An odd S accesses entry bits 63:32, and an even S accesses bits 31:0.
- R5: A window write whose entry index is NPINS or more changes no state, and a read of such an index returns zero. Select values 3 to 15 fall in this case through the wrap of the subtraction.
- R6: A low-half write clears the entry's remote-IRR bit 14 and overrides a same-cycle `rirr_set`. A high-half write leaves bit 14 unchanged. A `rirr_set` bit sets bit 14 of its entry.
- R7: In the cycle after a low-half write changes an entry's mask bit 16, `mask_chg_vld` is high for one cycle, with `mask_chg_pin` holding the entry index and `mask_chg_val` holding the new mask value.
- R8: In the cycle after any accepted write to a valid entry whose `pend_req` bit was set before that edge, `svc_vld` is high for one cycle and `svc_pin` holds the entry index.
- R9: A write is accepted only when `bus_len` is 4 or 8, and only `bus_wdata[31:0]` is used. A write with any other length changes no state.
- R10: Reset (asynchronous, active low) sets every entry to 0x10000 (mask set, all else zero) and clears the select register, the ID and `pend_req`.
- R11: On each clock edge, `pend_req` becomes (`pend_req` | `req_set`) & ~`req_clr`.
- R12: Entry i appears at `route_tbl[64*i+63 : 64*i]`. Its fields are vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-IRR 14, trigger mode 15, mask 16 and destination 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read enable for the combinational read data |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 64 | Write data; bits 31:0 are used |
| bus_rdata | output | 32 | Read data |
| req_set | input | NPINS | Pending-request set bits |
| req_clr | input | NPINS | Pending-request clear bits (clear wins) |
| rirr_set | input | NPINS | Remote-IRR set bits |
| pend_req | output | NPINS | Pending-request vector |
| route_tbl | output | 64*NPINS | Flattened routing table |
| mask_chg_vld | output | 1 | Mask-change pulse |
| mask_chg_pin | output | $clog2(NPINS) | Pin whose mask changed |
| mask_chg_val | output | 1 | New mask value |
| svc_vld | output | 1 | Service re-evaluate strobe |
| svc_pin | output | $clog2(NPINS) | Pin to re-evaluate |

## Verification
The hardest case to reach is the interaction that only arises when one edge carries three things at once: an entry write, a pending request on that same pin, and a same-cycle remote-IRR set or request update. The bench reaches it by driving `req_set`, `req_clr` and `rirr_set` at random alongside the bus writes. Those writes go to a small pool of select values that fall on and around the table edges: entries 0 and 23, index 24, and the wrapped values 3 to 15. A behavioural model holds the table as an array of 64-bit words and predicts each pulse from the pre-edge pending state. The model is compared on every clock with the exported table, the pending vector and both pulse outputs.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam logic [7:0]  OFS_SEL  = 8'h00;
  localparam logic [7:0]  OFS_WIN  = 8'h10;
  localparam logic [31:0] SEL_VER  = 32'd0;
  localparam logic [31:0] SEL_ID   = 32'd1;
  localparam logic [31:0] SEL_ARB  = 32'd2;
  localparam logic [31:0] ENT_BASE = 32'h10;
  localparam int B_RIRR = 14;
  localparam int B_MASK = 16;
  localparam logic [63:0] ENT_RST = 64'h1 << B_MASK;

  typedef enum logic [2:0] {WK_VER, WK_ID, WK_ARB, WK_ENT, WK_NONE} win_kind_e;

  // Entry index selected by a select value (wraps below ENT_BASE).
  function automatic logic [31:0] ent_index(input logic [31:0] sel);
    return (sel - ENT_BASE) >> 1;
  endfunction

  function automatic logic [31:0] ver_word(input int unsigned npins, input logic [7:0] ver);
    logic [7:0] top;
    top = 8'(npins - 1);
    return {8'h00, top, 8'h00, ver};
  endfunction

  function automatic logic [31:0] id_word(input logic [3:0] id);
    return {4'h0, id, 24'h0};
  endfunction

  function automatic logic len_ok(input logic [3:0] len);
    return (len == 4'd4) || (len == 4'd8);
  endfunction
endpackage

// File: rtl/irt_decode.sv
module irt_decode
  import irt_pkg::*;
#(
  parameter int unsigned NPINS  = 24,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned IDX_W = $clog2(NPINS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        len,
  input  logic [31:0]       sel,
  output logic              hit_sel,
  output logic              hit_win,
  output logic              acc_ok,
  output win_kind_e         kind,
  output logic [IDX_W-1:0]  idx,
  output logic              hi
);
  logic [31:0] full_idx;

  always_comb begin
    hit_sel  = (addr[7:0] == OFS_SEL);
    hit_win  = (addr[7:0] == OFS_WIN);
    acc_ok   = len_ok(len);
    full_idx = ent_index(sel);
    hi       = sel[0];
    case (sel)
      SEL_VER: kind = WK_VER;
      SEL_ID:  kind = WK_ID;
      SEL_ARB: kind = WK_ARB;
      default: kind = (full_idx < NPINS) ? WK_ENT : WK_NONE;
    endcase
    idx = (kind == WK_ENT) ? full_idx[IDX_W-1:0] : '0;
  end
endmodule

// File: rtl/irt_entry.sv
module irt_entry
  import irt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wd,
  input  logic        rirr_set,
  output logic [63:0] ent
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent <= ENT_RST;
    end else begin
      if (rirr_set) ent[B_RIRR] <= 1'b1;
      if (wr_hi)    ent[63:32]  <= wd;
      if (wr_lo) begin
        ent[31:0]   <= wd;
        ent[B_RIRR] <= 1'b0;
      end
    end
  end

  p_lo_clears_rirr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> !ent[B_RIRR]);
  p_rirr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !rirr_set) |=> (ent[B_RIRR] == $past(ent[B_RIRR])));
  p_rirr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_set && !wr_lo) |=> ent[B_RIRR]);
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irt_pkg::*;
#(
  parameter int unsigned NPINS   = 24,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int unsigned IDX_W  = $clog2(NPINS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [3:0]            bus_len,
  input  logic [63:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NPINS-1:0]      req_set,
  input  logic [NPINS-1:0]      req_clr,
  input  logic [NPINS-1:0]      rirr_set,
  output logic [NPINS-1:0]      pend_req,
  output logic [64*NPINS-1:0]   route_tbl,
  output logic                  mask_chg_vld,
  output logic [IDX_W-1:0]      mask_chg_pin,
  output logic                  mask_chg_val,
  output logic                  svc_vld,
  output logic [IDX_W-1:0]      svc_pin
);
  logic [31:0]      sel_q;
  logic [3:0]       id_q;
  logic [31:0]      wd;
  logic             hit_sel, hit_win, acc_ok, hi;
  win_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic [63:0]      ent [NPINS];

  // Named internal events
  logic we_sel, we_win, we_id, we_ent, we_lo, we_hi, mask_old, mask_flip, oob_wr;

  assign wd = bus_wdata[31:0];

  irt_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .len(bus_len), .sel(sel_q),
    .hit_sel(hit_sel), .hit_win(hit_win), .acc_ok(acc_ok),
    .kind(kind), .idx(idx), .hi(hi)
  );

  assign we_sel    = bus_wr && acc_ok && hit_sel;
  assign we_win    = bus_wr && acc_ok && hit_win;
  assign we_id     = we_win && (kind == WK_ID);
  assign we_ent    = we_win && (kind == WK_ENT);
  assign we_lo     = we_ent && !hi;
  assign we_hi     = we_ent && hi;
  assign oob_wr    = we_win && (kind == WK_NONE);
  assign mask_old  = ent[idx][B_MASK];
  assign mask_flip = we_lo && (wd[B_MASK] != mask_old);

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    irt_entry u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(we_lo && (idx == IDX_W'(g))),
      .wr_hi(we_hi && (idx == IDX_W'(g))),
      .wd(wd), .rirr_set(rirr_set[g]),
      .ent(ent[g])
    );
    assign route_tbl[64*g +: 64] = ent[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q        <= '0;
      id_q         <= '0;
      pend_req     <= '0;
      mask_chg_vld <= 1'b0;
      mask_chg_pin <= '0;
      mask_chg_val <= 1'b0;
      svc_vld      <= 1'b0;
      svc_pin      <= '0;
    end else begin
      if (we_sel) sel_q <= wd;
      if (we_id)  id_q  <= wd[27:24];
      pend_req     <= (pend_req | req_set) & ~req_clr;
      mask_chg_vld <= mask_flip;
      svc_vld      <= we_ent && pend_req[idx];
      if (mask_flip) begin
        mask_chg_pin <= idx;
        mask_chg_val <= wd[B_MASK];
      end
      if (we_ent) svc_pin <= idx;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_sel) bus_rdata = sel_q;
      else if (hit_win) begin
        case (kind)
          WK_VER:         bus_rdata = ver_word(NPINS, VERSION);
          WK_ID, WK_ARB:  bus_rdata = id_word(id_q);
          WK_ENT:         bus_rdata = hi ? ent[idx][63:32] : ent[idx][31:0];
          default:        bus_rdata = '0;
        endcase
      end
    end
  end

  p_len_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !len_ok(bus_len)) |=> ($stable(sel_q) && $stable(id_q)));
  p_ver_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_win && kind == WK_VER) |=> ($stable(id_q) && $stable(sel_q)));
  p_oob_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oob_wr && rirr_set == '0) |=> $stable(route_tbl));
  p_mask_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_vld |-> (route_tbl[64*mask_chg_pin + B_MASK] == mask_chg_val));
  p_svc_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_vld |-> $past(we_ent));
endmodule

// File: tb/irq_route_regfile_bench.sv
`timescale 1ns/1ps
module irq_route_regfile_bench;
  localparam int NP = 24;
  localparam int IW = 5;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_len = 4'd4;
  logic [63:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] req_set = '0, req_clr = '0, rirr_set = '0, pend_req;
  logic [64*NP-1:0] route_tbl;
  logic mask_chg_vld, mask_chg_val, svc_vld;
  logic [IW-1:0] mask_chg_pin, svc_pin;

  irq_route_regfile u_irq_route_regfile (.*);

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // Behavioural model
  logic [63:0] m_ent [NP];
  logic [31:0] m_sel;
  logic [3:0]  m_id;
  logic [NP-1:0] m_pend;
  bit m_mv, m_mval, m_sv;
  int m_mpin, m_spin;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_ent[i]) m_ent[i] = 64'h10000;
      m_sel = 0; m_id = 0; m_pend = 0; m_mv = 0; m_sv = 0;
    end else begin
      logic [NP-1:0] old_pend;
      old_pend = m_pend;
      m_mv = 0; m_sv = 0;
      for (int i = 0; i < NP; i++) if (rirr_set[i]) m_ent[i][14] = 1;
      if (bus_wr && (bus_len == 4 || bus_len == 8)) begin
        logic [31:0] d;
        d = bus_wdata[31:0];
        if (bus_addr[7:0] == 8'h00) m_sel = d;
        else if (bus_addr[7:0] == 8'h10) begin
          if (m_sel == 1) m_id = d[27:24];
          else if (m_sel > 2) begin
            longint unsigned k;
            k = (longint'(m_sel) + 64'h1_0000_0000 - 16) % 64'h1_0000_0000 / 2;
            if (k < NP) begin
              bit om;
              om = m_ent[k][16];
              if (m_sel[0]) m_ent[k][63:32] = d;
              else begin m_ent[k][31:0] = d; m_ent[k][14] = 0; end
              if (om != m_ent[k][16]) begin m_mv = 1; m_mpin = int'(k); m_mval = m_ent[k][16]; end
              if (old_pend[k]) begin m_sv = 1; m_spin = int'(k); end
            end
          end
        end
      end
      m_pend = (m_pend | req_set) & ~req_clr;
    end
  end

  function automatic logic [31:0] mread(input logic [11:0] a);
    if (a[7:0] == 8'h00) return m_sel;
    if (a[7:0] != 8'h10) return 0;
    if (m_sel == 0) return 32'h0017_0011;
    if (m_sel == 1 || m_sel == 2) return {4'h0, m_id, 24'h0};
    begin
      longint unsigned k;
      k = (longint'(m_sel) + 64'h1_0000_0000 - 16) % 64'h1_0000_0000 / 2;
      if (k >= NP) return 0;
      return m_sel[0] ? m_ent[k][63:32] : m_ent[k][31:0];
    end
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison of registered outputs (R12 table, R11 pending, R7/R8 pulses)
  always @(negedge clk) if (rst_n && !done) begin
    bit ok; int bad;
    ok = 1; bad = 0;
    for (int i = 0; i < NP; i++)
      if (route_tbl[64*i +: 64] !== m_ent[i]) begin ok = 0; bad = i; end
    check(ok, "R12 route_tbl entry", route_tbl[64*bad +: 64], m_ent[bad]);
    check(pend_req === m_pend, "R11 pend_req", 64'(pend_req), 64'(m_pend));
    check(mask_chg_vld === m_mv && (!m_mv || (mask_chg_pin == m_mpin && mask_chg_val == m_mval)),
          "R7 mask change", {mask_chg_vld, 7'd0, 3'd0, mask_chg_pin, 7'd0, mask_chg_val},
          {m_mv, 7'd0, 3'd0, 5'(m_mpin), 7'd0, m_mval});
    check(svc_vld === m_sv && (!m_sv || svc_pin == m_spin), "R8 service strobe",
          {svc_vld, 3'd0, svc_pin}, {m_sv, 3'd0, 5'(m_spin)});
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] len = 4);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = {32'hdead_beef, d}; bus_len = len;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1;
    check(bus_rdata === mread(a), tag, 64'(bus_rdata), 64'(mread(a)));
    bus_rd = 0;
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1;
    check(bus_rdata === e, tag, 64'(bus_rdata), 64'(e));
    bus_rd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    rd_exp(12'h000, 32'h0, "R10 select after reset");
    wr(12'h000, 32'h1);
    rd_exp(12'h010, 32'h0, "R10 ID after reset");
    wr(12'h000, 32'h10);
    rd_exp(12'h010, 32'h0001_0000, "R10 entry0 low after reset");
    // R1: decode
    wr(12'h000, 32'h1234_5678);
    rd_exp(12'h000, 32'h1234_5678, "R1 select readback");
    rd_exp(12'h020, 32'h0, "R1 other offset");
    rd_exp(12'h104, 32'h0, "R1 other offset 0x04");
    wr(12'h100, 32'h0);
    rd_exp(12'h000, 32'h0, "R1 upper address bits ignored");
    @(negedge clk); bus_addr = 12'h000; #1;
    check(bus_rdata === 0, "R1 no read without bus_rd", 64'(bus_rdata), 0);
    // R2: version
    rd_exp(12'h010, 32'h0017_0011, "R2 version word");
    wr(12'h010, 32'hffff_ffff);
    rd_exp(12'h010, 32'h0017_0011, "R2 version write ignored");
    // R3: ID and arbitration
    wr(12'h000, 32'h1); wr(12'h010, 32'hA5FF_FFFF);
    rd_exp(12'h010, 32'h0500_0000, "R3 ID readback");
    wr(12'h000, 32'h2);
    rd_exp(12'h010, 32'h0500_0000, "R3 arbitration mirrors ID");
    wr(12'h010, 32'h0C00_0000);
    rd_exp(12'h010, 32'h0500_0000, "R3 arbitration write ignored");
    // R4/R7: entry halves and mask change
    wr(12'h000, 32'h10); wr(12'h010, 32'h0000_A031);
    rd_exp(12'h010, 32'h0000_A031, "R4 entry0 low");
    wr(12'h000, 32'h3F); wr(12'h010, 32'hFE00_0000);
    rd_exp(12'h010, 32'hFE00_0000, "R4 entry23 high");
    wr(12'h000, 32'h3E);
    rd_exp(12'h010, 32'h0001_0000, "R4 entry23 low untouched");
    // R5: out of range
    wr(12'h000, 32'h40); wr(12'h010, 32'h0);
    rd_exp(12'h010, 32'h0, "R5 index 24 read");
    wr(12'h000, 32'h5); wr(12'h010, 32'h0);
    rd_exp(12'h010, 32'h0, "R5 wrapped select read");
    // R6: remote IRR
    @(negedge clk); rirr_set = 24'h80; @(negedge clk); rirr_set = 0;
    wr(12'h000, 32'h1F); wr(12'h010, 32'h1100_0000);
    wr(12'h000, 32'h1E);
    rd_exp(12'h010, 32'h0001_4000, "R6 high write keeps remote IRR");
    wr(12'h010, 32'h0001_4055);
    rd_exp(12'h010, 32'h0001_0055, "R6 low write clears remote IRR");
    // R8: service strobe
    @(negedge clk); req_set = 24'h8; @(negedge clk); req_set = 0;
    wr(12'h000, 32'h16); wr(12'h010, 32'h0000_0077);
    // R9: length
    wr(12'h000, 32'h3, 4'd2);
    rd_exp(12'h000, 32'h16, "R9 length 2 ignored");
    wr(12'h000, 32'h3, 4'd8);
    rd_exp(12'h000, 32'h3, "R9 length 8 accepted");
    // Mixed random stimulus
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom % 8;
      @(negedge clk);
      req_set  = ($urandom % 4 == 0) ? NP'($urandom) : '0;
      req_clr  = ($urandom % 4 == 0) ? NP'($urandom) : '0;
      rirr_set = ($urandom % 4 == 0) ? NP'($urandom) : '0;
      if (op < 2) begin
        logic [31:0] s;
        case ($urandom % 5)
          0: s = $urandom % 3;
          1: s = 3 + $urandom % 13;
          2: s = 16 + $urandom % 50;
          3: s = $urandom % 2 ? 32'h3E : 32'h3F;
          default: s = $urandom;
        endcase
        bus_wr = 1; bus_addr = 12'h000; bus_len = 4; bus_wdata = {32'h0, s};
      end else if (op < 6) begin
        bus_wr = 1; bus_addr = 12'h010;
        bus_len = ($urandom % 6 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'd4 : 4'd8);
        bus_wdata = {$urandom, $urandom};
      end else begin
        bus_wr = 0;
        bus_rd = 1; bus_addr = ($urandom % 2) ? 12'h010 : 12'($urandom);
        #1;
        check(bus_rdata === mread(bus_addr), "R4 random read", 64'(bus_rdata), 64'(mread(bus_addr)));
        bus_rd = 0;
      end
      @(negedge clk);
      bus_wr = 0; req_set = 0; req_clr = 0; rirr_set = 0;
    end
    // R10: reset mid-run
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(12'h000, "R10 select after second reset");
    finish_run();
  end
endmodule